// File: doc/BRIEF.md
# Two-Channel UART Sleep Controller

This controller decides when the clocks of a two-channel UART core may be stopped and when they must run again. It runs on an always-on clock. It watches three kinds of input: the enable bits held in the register file, the per-channel FIFO, shift-register and interrupt status, and the raw receive and modem lines. From these it drives a registered clock-enable request to a downstream glitch-free gate. The same request stops both the core clock and the baud-rate clock. The controller also reports through a flag whether the device is asleep.

Sleep can only be entered when the enhanced-function bit is set and every channel has its sleep-enable bit set. Both channels must also be quiet at the same moment. Once asleep, the device wakes on any of these events:
- a start bit on either receive line;
- a write into either transmit FIFO;
- any movement on a modem input.

After waking, the device falls asleep again on its own once everything is quiet. A separate low-power pin overrides all of this. While the pin is asserted, the clocks are stopped and the host inputs are isolated.

An external pin or line reaches the state machine through a two-flop synchronizer. Firmware must clear sleep enable before it writes the baud divisor, because a divisor write is not allowed while the device is asleep.

Top module: `uart_doze_ctrl`

## Requirements
- R1: While reset is applied and directly after it, the outputs are core_clk_en=1, sleep_flag=0, host_iso=0.
- R2: Sleep is permitted only while enh_en=1 and both ch_sleep_en bits are 1. If any of these is cleared while asleep, core_clk_en returns to 1 one clock later, and the device stays awake for as long as any of them is 0.
- R3: Sleep entry requires all of the following on both channels: txf_empty=1, txsr_empty=1, rxf_empty=1, irq_pend=0, and no modem input change. Any single channel failing any one of these keeps the device awake.
- R4: With rx_bypass=0, sleep entry also requires each synchronized rx_line to have been high for 4×char_bits baud_tick pulses since it was last low. A low line restarts that count from zero. With rx_bypass=1, the receive lines are ignored for sleep entry.
- R5: While asleep, core_clk_en=0 and sleep_flag=1. Exactly one of core_clk_en, sleep_flag and host_iso is 1 at any time after reset.
- R6: Each of the following wakes a sleeping device: a falling edge on either rx_line, a txf_wr pulse on either channel, or a change of any mdm_in bit.
- R7: After a wake, the device returns to sleep by itself as soon as R2, R3 and R4 hold again and no wake event is present in that cycle.
- R8: While the synchronized lp_pin is 1, host_iso=1 and core_clk_en=0, whatever the other inputs are. Only deasserting the pin leaves this state. On leaving, the device is awake and the receive idle counts restart from zero.
- R9: rx_line, mdm_in and lp_pin pass through two flops, so the outputs react on the third clock edge after such an input changes. A txf_wr pulse wakes the device on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_an | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enh_en | input | 1 | Enhanced-function enable bit |
| ch_sleep_en | input | NCH | Per-channel sleep-enable bits |
| rx_bypass | input | 1 | 1: ignore receive-line idleness for sleep entry |
| txf_empty | input | NCH | Transmit FIFO empty, per channel |
| txsr_empty | input | NCH | Transmit shift register empty, per channel |
| rxf_empty | input | NCH | Receive FIFO empty, per channel |
| irq_pend | input | NCH | Interrupt pending, per channel |
| rx_line | input | NCH | Raw serial receive lines (asynchronous) |
| mdm_in | input | NCH*NMDM | Raw modem input pins (asynchronous) |
| txf_wr | input | NCH | One-cycle strobe: a byte was written to the transmit FIFO |
| baud_tick | input | 1 | One-cycle baud-rate tick on clk_aon |
| char_bits | input | CHW | Configured bits per character |
| lp_pin | input | 1 | Low-power pin (asynchronous) |
| core_clk_en | output | 1 | Registered request to run the UART and baud clocks |
| sleep_flag | output | 1 | Device is in sleep |
| host_iso | output | 1 | Low-power state: clocks stopped, host inputs isolated |

## Verification
The assertions assume the following about the inputs:
- The status inputs, txf_wr and baud_tick are synchronous to clk_aon.
- txf_wr is a single-cycle strobe.
- char_bits is nonzero and does not change while a receive line is being timed.

The stimulus follows these rules. Every input changes only at the falling clock edge, and char_bits is set once to 8. baud_tick comes from a fixed one-in-four pulse train. Each txf_wr is held for exactly one cycle. The asynchronous pins are toggled just as the status inputs are, and the expected reaction times allow for the two synchronizer flops.

// File: rtl/doze_pkg.sv
package doze_pkg;
  typedef enum logic [1:0] {
    PM_AWAKE  = 2'd0,
    PM_ASLEEP = 2'd1,
    PM_LOWPWR = 2'd2
  } pm_state_e;
endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
  parameter int unsigned    W    = 1,
  parameter logic [W-1:0]   RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RSTV;
      q      <= RSTV;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/doze_rx_idle.sv
module doze_rx_idle #(
  parameter int unsigned CHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           tick,
  input  logic           rx_s,
  input  logic [CHW-1:0] char_bits,
  output logic           idle
);
  localparam int unsigned CNTW = CHW + 2;

  logic [CNTW-1:0] cnt_q, cnt_d, limit;

  assign limit = {char_bits, 2'b00};

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !rx_s) begin
      cnt_d = '0;
    end else if (tick && (cnt_q < limit)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idle = rx_s && (cnt_q >= limit);

  // R4: a low line forbids an idle indication on the following cycle
  p_low_clears_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_s && (char_bits != '0) && $stable(char_bits)) |=> !idle);
  // R8: a restart leaves the line non-idle next cycle
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (char_bits != '0)) |=> !idle);
endmodule

// File: rtl/doze_fsm.sv
module doze_fsm
  import doze_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic quiet,
  input  logic wake,
  input  logic lp,
  output logic restart,
  output logic clk_en,
  output logic sleep_flag,
  output logic iso
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_AWAKE:  if (allow && quiet && !wake) state_d = PM_ASLEEP;
      PM_ASLEEP: if (!allow || wake)          state_d = PM_AWAKE;
      PM_LOWPWR: if (!lp)                     state_d = PM_AWAKE;
      default:                                state_d = PM_AWAKE;
    endcase
    if (lp) state_d = PM_LOWPWR;
  end

  assign restart = (state_q == PM_LOWPWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PM_AWAKE;
      clk_en     <= 1'b1;
      sleep_flag <= 1'b0;
      iso        <= 1'b0;
    end else begin
      state_q    <= state_d;
      clk_en     <= (state_d == PM_AWAKE);
      sleep_flag <= (state_d == PM_ASLEEP);
      iso        <= (state_d == PM_LOWPWR);
    end
  end

  p_one_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clk_en, sleep_flag, iso}) == 1);
  p_asleep_no_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> !clk_en);
  p_disable_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !lp) |=> clk_en);
  p_entry_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> $past(quiet && allow && !wake));
  p_wake_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_flag && wake && !lp) |=> clk_en);
  p_lp_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> (iso && !clk_en));
endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned NMDM = 4,
  parameter int unsigned CHW  = 4
) (
  input  logic                clk_aon,
  input  logic                rst_an,
  input  logic                enh_en,
  input  logic [NCH-1:0]      ch_sleep_en,
  input  logic                rx_bypass,
  input  logic [NCH-1:0]      txf_empty,
  input  logic [NCH-1:0]      txsr_empty,
  input  logic [NCH-1:0]      rxf_empty,
  input  logic [NCH-1:0]      irq_pend,
  input  logic [NCH-1:0]      rx_line,
  input  logic [NCH*NMDM-1:0] mdm_in,
  input  logic [NCH-1:0]      txf_wr,
  input  logic                baud_tick,
  input  logic [CHW-1:0]      char_bits,
  input  logic                lp_pin,
  output logic                core_clk_en,
  output logic                sleep_flag,
  output logic                host_iso
);
  localparam int unsigned MW = NCH * NMDM;

  logic [1:0]     rst_pipe;
  logic           rst_n;
  logic [NCH-1:0] rx_s, rx_prev, rx_fall, rx_idle;
  logic [MW-1:0]  mdm_s, mdm_prev;
  logic           lp_s, mdm_chg, allow, quiet, wake, restart;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_aon or negedge rst_an) begin
    if (!rst_an) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  doze_sync #(.W(NCH), .RSTV({NCH{1'b1}})) u_rx_sync (
    .clk(clk_aon), .rst_n(rst_n), .d(rx_line), .q(rx_s));
  doze_sync #(.W(MW), .RSTV({MW{1'b0}})) u_mdm_sync (
    .clk(clk_aon), .rst_n(rst_n), .d(mdm_in), .q(mdm_s));
  doze_sync #(.W(1), .RSTV(1'b0)) u_lp_sync (
    .clk(clk_aon), .rst_n(rst_n), .d(lp_pin), .q(lp_s));

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev  <= {NCH{1'b1}};
      mdm_prev <= '0;
    end else begin
      rx_prev  <= rx_s;
      mdm_prev <= mdm_s;
    end
  end

  assign rx_fall = rx_prev & ~rx_s;
  assign mdm_chg = |(mdm_s ^ mdm_prev);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    doze_rx_idle #(.CHW(CHW)) u_idle (
      .clk       (clk_aon),
      .rst_n     (rst_n),
      .restart   (restart),
      .tick      (baud_tick),
      .rx_s      (rx_s[c]),
      .char_bits (char_bits),
      .idle      (rx_idle[c])
    );
  end

  assign allow = enh_en & (&ch_sleep_en);
  assign quiet = (&txf_empty) & (&txsr_empty) & (&rxf_empty) & ~(|irq_pend)
               & ~mdm_chg & (rx_bypass | (&rx_idle));
  assign wake  = (|rx_fall) | (|txf_wr) | mdm_chg;

  doze_fsm u_fsm (
    .clk        (clk_aon),
    .rst_n      (rst_n),
    .allow      (allow),
    .quiet      (quiet),
    .wake       (wake),
    .lp         (lp_s),
    .restart    (restart),
    .clk_en     (core_clk_en),
    .sleep_flag (sleep_flag),
    .iso        (host_iso)
  );

  // R4: a low synchronized line with no bypass blocks sleep entry
  p_rx_low_blocks_r4: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (!rx_bypass && !(&rx_s) && !sleep_flag) |=> !sleep_flag);
  // R3: a busy channel never lets an awake device fall asleep
  p_busy_blocks_r3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (core_clk_en && ((|irq_pend) || !(&txf_empty))) |=> !sleep_flag);
endmodule

// File: tb/uart_doze_ctrl_tb.sv
module uart_doze_ctrl_tb;
  logic       clk_aon = 1'b0;
  logic       rst_an, enh_en, rx_bypass, baud_tick, lp_pin;
  logic [1:0] ch_sleep_en, txf_empty, txsr_empty, rxf_empty, irq_pend, rx_line, txf_wr;
  logic [7:0] mdm_in;
  logic [3:0] char_bits;
  logic       core_clk_en, sleep_flag, host_iso;
  int         n_chk = 0, n_bad = 0;

  always #5 clk_aon = ~clk_aon;

  uart_doze_ctrl u_dut (.*);

  localparam logic [2:0] AWAKE = 3'b100, ASLEEP = 3'b010, LOWP = 3'b001;

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk_aon);
      baud_tick = 1'b1;
      @(negedge clk_aon);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {core_clk_en, sleep_flag, host_iso};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {clk_en,sleep,iso} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_aon);
  endtask

  task automatic t_reset;
    rst_an = 1'b0; enh_en = 1'b1; ch_sleep_en = 2'b11; rx_bypass = 1'b0;
    txf_empty = 2'b11; txsr_empty = 2'b11; rxf_empty = 2'b11; irq_pend = 2'b00;
    rx_line = 2'b11; mdm_in = 8'h5A; txf_wr = 2'b00; char_bits = 4'd8; lp_pin = 1'b0;
    step(3);
    chk("R1 during reset", AWAKE);
    rst_an = 1'b1;
    step(4);
    chk("R1 after release", AWAKE);
  endtask

  task automatic t_idle;
    step(76);
    chk("R4 line idle under four characters", AWAKE);
    step(90);
    chk("R4 line idle four characters", ASLEEP);
  endtask

  task automatic t_rx_wake;
    rx_line[1] = 1'b0;
    step(2);
    chk("R9 rx fall before sync", ASLEEP);
    step(1);
    chk("R6 rx start bit wakes", AWAKE);
    rx_line[1] = 1'b1;
    step(80);
    chk("R4 idle count restarted by low line", AWAKE);
    step(100);
    chk("R7 back to sleep after rx wake", ASLEEP);
  endtask

  task automatic t_override;
    ch_sleep_en = 2'b10;
    step(1);
    chk("R2 clearing one sleep enable wakes", AWAKE);
    rx_bypass = 1'b1;
    rx_line[0] = 1'b0;
    step(6);
    ch_sleep_en = 2'b11;
    step(2);
    chk("R4 bypass ignores low rx line", ASLEEP);
    rx_line[0] = 1'b1;
    step(4);
    chk("R6 rising rx edge is no wake", ASLEEP);
  endtask

  task automatic t_enable;
    enh_en = 1'b0;
    step(1);
    chk("R2 enhanced bit cleared wakes", AWAKE);
    step(10);
    chk("R2 stays awake while disabled", AWAKE);
    enh_en = 1'b1;
    step(2);
    chk("R2 re-enabled sleeps", ASLEEP);
  endtask

  task automatic t_quiet;
    for (int k = 0; k < 8; k++) begin
      ch_sleep_en = 2'b00;
      step(1);
      case (k / 2)
        0: txf_empty[k % 2]  = 1'b0;
        1: txsr_empty[k % 2] = 1'b0;
        2: rxf_empty[k % 2]  = 1'b0;
        default: irq_pend[k % 2] = 1'b1;
      endcase
      ch_sleep_en = 2'b11;
      step(5);
      chk($sformatf("R3 blocker %0d holds awake", k), AWAKE);
      txf_empty = 2'b11; txsr_empty = 2'b11; rxf_empty = 2'b11; irq_pend = 2'b00;
      step(2);
      chk($sformatf("R3 blocker %0d cleared sleeps", k), ASLEEP);
    end
  endtask

  task automatic t_txw;
    txf_wr[1] = 1'b1; txf_empty[1] = 1'b0;
    step(1);
    txf_wr = 2'b00;
    chk("R9 txf_wr wakes on first edge", AWAKE);
    step(5);
    chk("R3 non-empty FIFO keeps awake", AWAKE);
    txf_empty[1] = 1'b1;
    step(2);
    chk("R7 back to sleep after tx write", ASLEEP);
  endtask

  task automatic t_modem;
    mdm_in[5] = ~mdm_in[5];
    step(2);
    chk("R9 modem change before sync", ASLEEP);
    step(1);
    chk("R6 modem change wakes", AWAKE);
    step(1);
    chk("R7 modem wake returns to sleep", ASLEEP);
  endtask

  task automatic t_lowpwr;
    rx_bypass = 1'b0;
    lp_pin = 1'b1;
    step(2);
    chk("R9 lp pin before sync", ASLEEP);
    step(1);
    chk("R8 lp pin forces low power", LOWP);
    txf_wr = 2'b01; enh_en = 1'b0; mdm_in[0] = ~mdm_in[0];
    step(1);
    txf_wr = 2'b00;
    step(10);
    chk("R8 low power ignores wake and disable", LOWP);
    enh_en = 1'b1;
    lp_pin = 1'b0;
    step(3);
    chk("R8 lp release returns awake", AWAKE);
    step(60);
    chk("R8 idle counts restarted on release", AWAKE);
    step(120);
    chk("R7 sleeps again after low power", ASLEEP);
  endtask

  initial begin
    repeat (20000) @(posedge clk_aon);
    n_bad++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_idle;
    t_rx_wake;
    t_override;
    t_enable;
    t_quiet;
    t_txw;
    t_modem;
    t_lowpwr;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule